// File: doc/BRIEF.md
# Supply Voltage Monitor Control Register

This block is an 8-bit status and control register for a supply-voltage monitor. Two comparators outside the block drive it. One reports that the supply has dropped below a warning level. The other reports that the supply has dropped below a detect level. Both inputs are asynchronous, so each one passes through a two-flop synchronizer before any logic uses it.

Software reads and writes the register over a simple bus: a write strobe, write data, and read data that is always valid. A sticky warning flag records every warning. Software clears it by writing an acknowledge bit, and the clear only takes effect once the warning has gone away.

Three level outputs come out of the register:
- an interrupt request for the warning;
- a reset request for detect events, gated by two enables and by stop mode;
- an enable for a reference-voltage buffer.

The enable for the detect logic and the enable for reset generation can each be written only once after reset.

Top module: `lvm_ctrl`

## Requirements
- R1: The read value packs the fields as follows: bit 7 warning flag, bit 5 interrupt enable, bit 4 reset enable, bit 3 stop enable, bit 2 detect enable, bit 0 buffer enable. A write uses the same positions, and a 1 in bit 6 is the acknowledge.
- R2: Once synchronous reset has been applied, the register reads 8'h1C: detect, reset and stop enables set, everything else clear.
- R3: The warning flag becomes 1 on the clock edge after the synchronized warning input is seen high. The synchronized input lags the pin by two clocks. The flag therefore also sets after reset if the pin was already high during reset.
- R4: A write with bit 6 set clears the flag only when the synchronized warning input is low at that edge. Otherwise the flag stays 1.
- R5: irq_o is 1 exactly while the flag and the interrupt enable are both 1.
- R6: Bits 4 and 2 take their value from the first write after reset only. Later writes leave them unchanged. Bits 5, 3 and 0 are written on every write.
- R7: rst_req_o is 1 only while the synchronized detect input, the detect enable and the reset enable are all 1.
- R8: While stop_i is 1, rst_req_o also requires the stop enable to be 1. While stop_i is 0, the stop enable has no effect on rst_req_o.
- R9: buf_en_o equals the buffer enable bit (bit 0).
- R10: Bits 6 and 1 always read 0. Writing them stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register value |
| warn_cmp_i | input | 1 | Asynchronous warning-level comparator output |
| detect_cmp_i | input | 1 | Asynchronous detect-level comparator output |
| stop_i | input | 1 | Stop-mode indication |
| irq_o | output | 1 | Warning interrupt request |
| rst_req_o | output | 1 | Reset request from a detect event |
| buf_en_o | output | 1 | Reference buffer enable |

## Verification
An acknowledge write can land on the same clock edge where the synchronized warning turns active. In that case the set must win and the flag must stay 1.

To reach that edge, the bench raises the warning pin and then issues acknowledge writes at every offset from zero to four cycles later. It also repeats this with random stimulus.

A behavioural model tracks the two-cycle synchronizer delay with queues and predicts the flag on every clock. This shows whether the acknowledge was honoured or refused on exactly the right edge.

// File: rtl/lvm_pkg.sv
package lvm_pkg;

    localparam int REG_W      = 8;
    localparam int POS_FLAG   = 7;
    localparam int POS_ACK    = 6;
    localparam int POS_IRQEN  = 5;
    localparam int POS_RSTEN  = 4;
    localparam int POS_STOPEN = 3;
    localparam int POS_DETEN  = 2;
    localparam int POS_RSVD   = 1;
    localparam int POS_BUFEN  = 0;

    typedef struct packed {
        logic irq_en;
        logic rst_en;
        logic stop_en;
        logic det_en;
        logic buf_en;
    } lvm_ctrl_t;

    localparam lvm_ctrl_t CTRL_RST = '{irq_en: 1'b0, rst_en: 1'b1,
                                       stop_en: 1'b1, det_en: 1'b1,
                                       buf_en: 1'b0};

    typedef struct packed {
        logic warn;
        logic detect;
    } lvm_cmp_t;

    // Next control state for a write; the once-only fields move only while unlocked.
    function automatic lvm_ctrl_t ctrl_write(lvm_ctrl_t cur,
                                             logic [REG_W-1:0] d,
                                             logic locked);
        lvm_ctrl_t n;
        n         = cur;
        n.irq_en  = d[POS_IRQEN];
        n.stop_en = d[POS_STOPEN];
        n.buf_en  = d[POS_BUFEN];
        if (!locked) begin
            n.rst_en = d[POS_RSTEN];
            n.det_en = d[POS_DETEN];
        end
        return n;
    endfunction

    function automatic logic ack_bit(logic [REG_W-1:0] d);
        return d[POS_ACK];
    endfunction

    function automatic logic [REG_W-1:0] pack_read(logic flag, lvm_ctrl_t c);
        logic [REG_W-1:0] r;
        r             = '0;
        r[POS_FLAG]   = flag;
        r[POS_ACK]    = 1'b0;
        r[POS_IRQEN]  = c.irq_en;
        r[POS_RSTEN]  = c.rst_en;
        r[POS_STOPEN] = c.stop_en;
        r[POS_DETEN]  = c.det_en;
        r[POS_RSVD]   = 1'b0;
        r[POS_BUFEN]  = c.buf_en;
        return r;
    endfunction

endpackage

// File: rtl/lvm_sync.sv
module lvm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[LAST];
endmodule

// File: rtl/lvm_ctrl_reg.sv
module lvm_ctrl_reg
    import lvm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output lvm_ctrl_t        ctrl_o,
    output logic             ack_o
);
    lvm_ctrl_t ctrl_q;
    logic      locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RST;
            locked_q <= 1'b0;
        end else if (wr_en) begin
            ctrl_q   <= ctrl_write(ctrl_q, wr_data, locked_q);
            locked_q <= 1'b1;
        end
    end

    assign ctrl_o = ctrl_q;
    assign ack_o  = wr_en & ack_bit(wr_data);
endmodule

// File: rtl/lvm_warn_flag.sv
module lvm_warn_flag (
    input  logic clk,
    input  logic rst,
    input  logic warn_sync,
    input  logic ack,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (warn_sync) begin
            flag_q <= 1'b1;
        end else if (ack) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/lvm_req.sv
module lvm_req
    import lvm_pkg::*;
(
    input  lvm_ctrl_t ctrl,
    input  logic      flag,
    input  logic      detect_sync,
    input  logic      stop,
    output logic      irq_o,
    output logic      rst_req_o
);
    logic monitor_live;

    always_comb begin
        monitor_live = ctrl.det_en & (~stop | ctrl.stop_en);
        irq_o        = flag & ctrl.irq_en;
        rst_req_o    = detect_sync & monitor_live & ctrl.rst_en;
    end
endmodule

// File: rtl/lvm_ctrl.sv
module lvm_ctrl
    import lvm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             warn_cmp_i,
    input  logic             detect_cmp_i,
    input  logic             stop_i,
    output logic             irq_o,
    output logic             rst_req_o,
    output logic             buf_en_o
);
    localparam int CMP_W = $bits(lvm_cmp_t);

    lvm_cmp_t  cmp_raw;
    lvm_cmp_t  cmp_sync;
    lvm_ctrl_t ctrl;
    logic      ack;
    logic      flag;

    assign cmp_raw = '{warn: warn_cmp_i, detect: detect_cmp_i};

    lvm_sync #(.WIDTH(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (cmp_raw),
        .dout (cmp_sync)
    );

    lvm_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_o  (ctrl),
        .ack_o   (ack)
    );

    lvm_warn_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .warn_sync (cmp_sync.warn),
        .ack       (ack),
        .flag_o    (flag)
    );

    lvm_req u_req (
        .ctrl        (ctrl),
        .flag        (flag),
        .detect_sync (cmp_sync.detect),
        .stop        (stop_i),
        .irq_o       (irq_o),
        .rst_req_o   (rst_req_o)
    );

    assign rd_data  = pack_read(flag, ctrl);
    assign buf_en_o = ctrl.buf_en;
endmodule

// File: rtl/lvm_ctrl_chk.sv
module lvm_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       stop_i,
    input logic       irq_o,
    input logic       rst_req_o,
    input logic       buf_en_o
);
    logic locked_q;

    always_ff @(posedge clk) begin
        if (rst)        locked_q <= 1'b0;
        else if (wr_en) locked_q <= 1'b1;
    end

    AST_RESET_VALUE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rd_data == 8'h1C);  // R2
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_data[7] && !(wr_en && wr_data[6])) |=> rd_data[7]);  // R3
    AST_FLAG_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ($fell(rd_data[7]) && !$past(rst)) |-> $past(wr_en && wr_data[6]));  // R4
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
        irq_o == (rd_data[7] && rd_data[5]));  // R5
    AST_WRITE_ONCE: assert property (@(posedge clk) disable iff (rst)
        (locked_q && wr_en) |=> (rd_data[4] == $past(rd_data[4]) && rd_data[2] == $past(rd_data[2])));  // R6
    AST_RST_REQ_GATE: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> (rd_data[2] && rd_data[4]));  // R7
    AST_STOP_GATE: assert property (@(posedge clk) disable iff (rst)
        (rst_req_o && stop_i) |-> rd_data[3]);  // R8
    AST_BUF_LEVEL: assert property (@(posedge clk) disable iff (rst)
        buf_en_o == rd_data[0]);  // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_data[6] && !rd_data[1]);  // R10
endmodule

bind lvm_ctrl lvm_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .stop_i    (stop_i),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o),
    .buf_en_o  (buf_en_o)
);

// File: tb/tb_lvm_ctrl.sv
module tb_lvm_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       warn_cmp_i = 1'b0;
    logic       detect_cmp_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       irq_o;
    logic       rst_req_o;
    logic       buf_en_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    lvm_ctrl dut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .warn_cmp_i   (warn_cmp_i),
        .detect_cmp_i (detect_cmp_i),
        .stop_i       (stop_i),
        .irq_o        (irq_o),
        .rst_req_o    (rst_req_o),
        .buf_en_o     (buf_en_o)
    );

    always #10 clk = ~clk;

    // Behavioural reference model
    bit m_flag, m_ie, m_rsten, m_stopen, m_deten, m_buf, m_locked;
    bit wq[$];
    bit dq[$];

    task automatic model_reset();
        m_flag = 0; m_ie = 0; m_rsten = 1; m_stopen = 1; m_deten = 1;
        m_buf = 0; m_locked = 0;
        wq = {1'b0, 1'b0};
        dq = {1'b0, 1'b0};
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            if (wq[$]) m_flag = 1;
            else if (wr_en && wr_data[6]) m_flag = 0;
            if (wr_en) begin
                m_ie = wr_data[5]; m_stopen = wr_data[3]; m_buf = wr_data[0];
                if (!m_locked) begin
                    m_rsten = wr_data[4];
                    m_deten = wr_data[2];
                end
                m_locked = 1;
            end
            void'(wq.pop_back()); wq.push_front(warn_cmp_i);
            void'(dq.pop_back()); dq.push_front(detect_cmp_i);
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 R4 flag", rd_data[7], m_flag);
            chk("R1 R6 R10 control bits", {rd_data[6:0]},
                {1'b0, m_ie, m_rsten, m_stopen, m_deten, 1'b0, m_buf});
            chk("R5 irq", irq_o, m_flag & m_ie);
            chk("R7 R8 rst_req", rst_req_o,
                dq[$] & m_deten & m_rsten & (!stop_i | m_stopen));
            chk("R9 buffer", buf_en_o, m_buf);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic do_write(logic [7:0] d);
        wr_en = 1; wr_data = d;
        step(1);
        wr_en = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        step(3);
        rst = 0;
    endtask

    initial begin : watchdog
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Warning already present across reset: R3
        warn_cmp_i = 1;
        step(1);
        do_reset();
        @(negedge clk);
        chk("R2 reset value", rd_data, 8'h1C);
        #2;
        step(4);
        chk("R3 flag after reset", rd_data[7], 1);
        // Acknowledge while warning active is refused: R4
        do_write(8'h5C);
        step(1);
        chk("R4 ack refused", rd_data[7], 1);
        warn_cmp_i = 0;
        step(4);
        do_write(8'h40);
        step(1);
        chk("R4 ack honoured", rd_data[7], 0);
        // Write-once lock: R6
        do_write(8'h00);
        chk("R6 write-once after lock", rd_data & 8'h14, 8'h14);
        do_reset();
        do_write(8'h00);
        do_write(8'h3D);
        step(1);
        chk("R6 first write sticks", rd_data & 8'h14, 8'h00);
        chk("R10 reserved reads 0", rd_data & 8'h42, 8'h00);
        // Ack racing the synchronized warning edge, all offsets: R4
        for (int off = 0; off < 5; off++) begin
            do_reset();
            do_write(8'h3D);
            warn_cmp_i = 1;
            step(off);
            do_write(8'h7D);
            warn_cmp_i = 0;
            step(4);
            chk("R4 race flag set", rd_data[7], 1);
        end
        // Detect gating by stop mode: R7 R8
        do_reset();
        do_write(8'h14);
        detect_cmp_i = 1;
        step(3);
        chk("R7 rst_req run", rst_req_o, 1);
        stop_i = 1;
        step(1);
        chk("R8 stop gated", rst_req_o, 0);
        do_write(8'h1D);
        step(1);
        chk("R8 stop enabled", rst_req_o, 1);
        chk("R9 buffer on", buf_en_o, 1);
        detect_cmp_i = 0; stop_i = 0;
        // Random phase, with occasional reset
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            rst          = (r[3:0] == 4'd0) && (r[9:8] == 2'd0);
            wr_en        = r[5:4] == 2'd0;
            wr_data      = r[31:24];
            if (r[7:6] == 2'd0) warn_cmp_i = ~warn_cmp_i;
            if (r[11:10] == 2'd0) detect_cmp_i = ~detect_cmp_i;
            if (r[14:12] == 3'd0) stop_i = ~stop_i;
            step(1);
        end
        rst = 0; wr_en = 0;
        step(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule